// File: doc/BRIEF.md
# Multi-Channel Countdown Timer with Shared Prescaler

This block is a memory-mapped timer peripheral. A 16-bit prescaler counts down once per clock. Each time it passes zero it reloads itself and emits a one-cycle tick strobe. Every timer channel uses that strobe. Between one and eight channels count down on each tick. A channel signals an underflow when it takes a tick while already at zero. On underflow it can reload itself for periodic operation, or it can stop for one-shot operation. When enabled, it raises its own interrupt line for one cycle and latches a sticky pending flag.

Software uses the block through a simple word bus made of an address, a write strobe, write data and registered read data. The unit registers sit at the bottom of the map. Each channel has a 16-byte window above them. A read-only capability word reports how many channels there are and how their interrupts are routed.

Top module: `mtu_top`

## Requirements
- R1: After reset the prescaler value and prescaler reload read 0, every channel's counter, reload and control read 0, and all interrupt lines are low.
- R2: The prescaler value (offset 0x00) and prescaler reload (offset 0x04) are 16 bits wide. Write-data bits 31:16 are dropped, and those bits read as 0.
- R3: The `tick` strobe fires once every (prescaler reload + 1) clocks. A reload of 0 keeps `tick` high on every clock.
- R4: Offset 0x08 reads the constant capability word: bits 2:0 hold the channel count modulo 8, bits 7:3 the base interrupt line, bit 8 = 1 (one line per channel), bit 9 = 1 (no debug freeze). Writes to 0x08 have no effect. With the default parameters it reads 0x342.
- R5: Channel n has a window at 0x10 + 0x10*n: counter at +0x0, reload at +0x4, control at +0x8. Only address bits 7:0 are decoded, so higher address bits alias.
- R6: Offset +0xC in any window, and any window above the last channel, read 0. Writes to them change no register.
- R7: Control bits are: bit 0 enable, bit 1 auto-reload, bit 2 load (a write with it set copies reload into counter; it always reads 0), bit 3 interrupt enable, bit 4 pending.
- R8: An enabled channel decrements on each tick. A disabled channel holds its counter. In auto-reload mode underflows repeat every (reload+1) ticks, which is (reload+1)*(prescaler reload+1) clocks.
- R9: On underflow with interrupt enable set, the channel's `irq` bit is high for exactly one cycle, starting one clock after the underflowing tick, and pending is set. With interrupt enable clear, no pulse occurs and pending stays 0.
- R10: Pending is sticky. A control write with bit 4 = 1 clears it, and a control write with bit 4 = 0 leaves it unchanged.
- R11: Without auto-reload, an underflow clears the enable bit and the counter stays at 0.
- R12: Each channel drives only its own bit of `irq`.
- R13: Read data appears on `bus_rdata` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick | output | 1 | Shared prescaler tick strobe |
| irq | output | NUM_CH | One interrupt pulse line per channel |

## Verification
The prescaler is run with reload values 0 and 3. The single-cycle spacing shows that a zero reload does not stall the prescaler, and the four-cycle spacing shows the +1 in the divide. Channels run in three patterns. Auto-reload with interrupts on checks the product of the two periods. One-shot checks the exact cycle of the interrupt pulse and the stop behaviour. Auto-reload with interrupts off shows that counting continues while the line and the pending flag stay quiet. Running two channels in turn, together with accesses to unmapped offsets, aliased addresses and the read-only word, shows that decode and routing keep the channels apart.

// File: rtl/mtu_pkg.sv
package mtu_pkg;

  typedef struct packed {
    logic pend;
    logic ie;
    logic auto_rl;
    logic en;
  } ch_ctl_t;

  localparam int BIT_EN   = 0;
  localparam int BIT_AUTO = 1;
  localparam int BIT_LOAD = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_PEND = 4;

  function automatic logic [31:0] caps_word(int unsigned nch, int unsigned irq_base);
    logic [31:0] w;
    w      = '0;
    w[2:0] = nch[2:0];
    w[7:3] = irq_base[4:0];
    w[8]   = 1'b1;
    w[9]   = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] ctl_view(ch_ctl_t c);
    logic [31:0] w;
    w           = '0;
    w[BIT_EN]   = c.en;
    w[BIT_AUTO] = c.auto_rl;
    w[BIT_IE]   = c.ie;
    w[BIT_PEND] = c.pend;
    return w;
  endfunction

endpackage

// File: rtl/mtu_prescaler.sv
module mtu_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_val,
  input  logic          wr_rld,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] val,
  output logic [PW-1:0] rld,
  output logic          tick
);

  assign tick = (val == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      rld <= '0;
    end else begin
      if (wr_rld) rld <= wdata;
      if (wr_val)    val <= wdata;
      else if (tick) val <= rld;
      else           val <= val - 1'b1;
    end
  end

endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
  import mtu_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_rld,
  input  logic          wr_ctl,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld,
  output ch_ctl_t       ctl,
  output logic          irq,
  output logic          undf
);

  assign undf = tick & ctl.en & (cnt == '0) & ~wr_ctl & ~wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
      ctl <= '0;
      irq <= 1'b0;
    end else begin
      irq <= undf & ctl.ie;
      if (wr_rld) rld <= wdata[CW-1:0];
      if (wr_ctl) begin
        ctl.en      <= wdata[BIT_EN];
        ctl.auto_rl <= wdata[BIT_AUTO];
        ctl.ie      <= wdata[BIT_IE];
        if (wdata[BIT_PEND]) ctl.pend <= 1'b0;
        if (wdata[BIT_LOAD]) cnt <= rld;
      end else if (wr_cnt) begin
        cnt <= wdata[CW-1:0];
      end else if (undf) begin
        if (ctl.ie) ctl.pend <= 1'b1;
        if (ctl.auto_rl) cnt <= rld;
        else             ctl.en <= 1'b0;
      end else if (tick && ctl.en) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mtu_top.sv
module mtu_top
  import mtu_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8,
  parameter int ADDR_W   = 12,
  parameter int PW       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tick,
  output logic [NUM_CH-1:0] irq
);

  localparam int          CW   = 32;
  localparam logic [31:0] CAPS = caps_word(NUM_CH, IRQ_BASE);

  logic [3:0] slot;
  logic [1:0] word;
  logic       unit_sel;
  assign slot     = bus_addr[7:4];
  assign word     = bus_addr[3:2];
  assign unit_sel = (slot == 4'd0);

  logic          presc_wr;
  logic          presc_rld_wr;
  logic [PW-1:0] presc_val;
  logic [PW-1:0] presc_rld;
  assign presc_wr     = bus_we & unit_sel & (word == 2'd0);
  assign presc_rld_wr = bus_we & unit_sel & (word == 2'd1);

  mtu_prescaler #(.PW(PW)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_val (presc_wr),
    .wr_rld (presc_rld_wr),
    .wdata  (bus_wdata[PW-1:0]),
    .val    (presc_val),
    .rld    (presc_rld),
    .tick   (tick)
  );

  logic [NUM_CH-1:0] ch_sel;
  logic [NUM_CH-1:0] ch_undf;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] ch_auto;
  logic [CW-1:0]     ch_cnt [NUM_CH];
  logic [CW-1:0]     ch_rld [NUM_CH];
  ch_ctl_t           ch_ctl [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_sel[i]  = (slot == 4'(i + 1));
    assign ch_en[i]   = ch_ctl[i].en;
    assign ch_auto[i] = ch_ctl[i].auto_rl;

    mtu_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_cnt (bus_we & ch_sel[i] & (word == 2'd0)),
      .wr_rld (bus_we & ch_sel[i] & (word == 2'd1)),
      .wr_ctl (bus_we & ch_sel[i] & (word == 2'd2)),
      .wdata  (bus_wdata),
      .cnt    (ch_cnt[i]),
      .rld    (ch_rld[i]),
      .ctl    (ch_ctl[i]),
      .irq    (irq[i]),
      .undf   (ch_undf[i])
    );
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (unit_sel) begin
      case (word)
        2'd0:    rd_next = 32'(presc_val);
        2'd1:    rd_next = 32'(presc_rld);
        2'd2:    rd_next = CAPS;
        default: rd_next = '0;
      endcase
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) begin
        case (word)
          2'd0:    rd_next = ch_cnt[i];
          2'd1:    rd_next = ch_rld[i];
          2'd2:    rd_next = ctl_view(ch_ctl[i]);
          default: rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8,
  parameter int ADDR_W   = 12,
  parameter int PW       = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tick,
  input logic [NUM_CH-1:0] irq,
  input logic [PW-1:0]     presc_val,
  input logic [PW-1:0]     presc_rld,
  input logic              presc_wr,
  input logic [NUM_CH-1:0] ch_undf,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_auto
);

  localparam logic [31:0] CAPS_EXP =
    32'(NUM_CH % 8) | (32'(IRQ_BASE) << 3) | 32'h0000_0300;

  AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !presc_wr) |=> (presc_val == $past(presc_rld))); // R3

  AST_PRESC_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !presc_wr) |=> (presc_val == $past(presc_val) - 1'b1)); // R3

  AST_CAPS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:0] == 8'h08) |=> (bus_rdata == CAPS_EXP)); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr[3:2] == 2'b11) || (bus_addr[7:4] > 4'(NUM_CH))) |=> (bus_rdata == '0)); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(ch_undf)) == '0)); // R9

  for (genvar i = 0; i < NUM_CH; i++) begin : g_os
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_undf[i] && !ch_auto[i]) |=> !ch_en[i]); // R11
  end

endmodule

bind mtu_top mtu_checker #(
  .NUM_CH(NUM_CH), .IRQ_BASE(IRQ_BASE), .ADDR_W(ADDR_W), .PW(PW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tick      (tick),
  .irq       (irq),
  .presc_val (presc_val),
  .presc_rld (presc_rld),
  .presc_wr  (presc_wr),
  .ch_undf   (ch_undf),
  .ch_en     (ch_en),
  .ch_auto   (ch_auto)
);

// File: tb/mtu_top_bench.sv
module mtu_top_bench;

  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick;
  logic [NCH-1:0] irq;

  int checks = 0;
  int failures = 0;
  int irq_pulses [NCH];
  bit done = 1'b0;

  always #5 clk = ~clk;

  mtu_top #(.NUM_CH(NCH), .IRQ_BASE(8), .ADDR_W(12), .PW(16)) u_mtu_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .irq(irq)
  );

  initial for (int i = 0; i < NCH; i++) irq_pulses[i] = 0;
  always @(negedge clk)
    for (int i = 0; i < NCH; i++) if (irq[i]) irq_pulses[i] = irq_pulses[i] + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_irq(int ch, output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!irq[ch] && cycles < 1000);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq low", 32'(irq), 0);
    check("R3 tick with zero reload", 32'(tick), 1);
    bus_rd(12'h000, d); check("R1 prescaler value", d, 0);
    bus_rd(12'h004, d); check("R1 prescaler reload", d, 0);
    bus_rd(12'h010, d); check("R1 ch0 counter", d, 0);
    bus_rd(12'h024, d); check("R1 ch1 reload", d, 0);
    bus_rd(12'h018, d); check("R1 ch0 control", d, 0);
  endtask

  task automatic t_caps;
    logic [31:0] d;
    bus_rd(12'h008, d); check("R4 capability word", d, 32'h342);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_rd(12'h008, d); check("R4 write ignored", d, 32'h342);
    bus_rd(12'h508, d); check("R5 high address bits alias", d, 32'h342);
    @(negedge clk); bus_addr = 12'h00C;
    @(negedge clk); bus_addr = 12'h008;
    check("R13 old data before edge", bus_rdata, 0);
    @(negedge clk);
    check("R13 data one clock later", bus_rdata, 32'h342);
  endtask

  task automatic t_prescaler;
    logic [31:0] d;
    int gap;
    bus_wr(12'h004, 32'hABCD_0003);
    bus_rd(12'h004, d); check("R2 upper bits dropped", d, 32'h3);
    do @(negedge clk); while (!tick);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick && gap < 100);
    check("R3 tick spacing reload 3", 32'(gap), 4);
    bus_wr(12'h004, 32'h0);
    repeat (6) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R3 tick every clock at reload 0", 32'(tick), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    int c;
    bus_wr(12'h004, 32'h1);
    bus_wr(12'h014, 32'h4);
    bus_wr(12'h018, 32'h0000_000F);
    wait_irq(0, c);
    wait_irq(0, c);
    check("R8 auto-reload period (4+1)*(1+1)", 32'(c), 10);
    @(negedge clk);
    check("R9 pulse lasts one cycle", 32'(irq[0]), 0);
    bus_rd(12'h018, d); check("R7 control readback, load reads 0", d, 32'h1B);
    bus_wr(12'h018, 32'h10);
    bus_rd(12'h018, d); check("R10 pending cleared and stopped", d, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    int p1;
    bus_wr(12'h004, 32'h0);
    repeat (4) @(negedge clk);
    p1 = irq_pulses[1];
    bus_wr(12'h014, 32'h5);
    bus_wr(12'h018, 32'h0000_000D);
    repeat (5) @(negedge clk);
    check("R9 no pulse before underflow", 32'(irq[0]), 0);
    @(negedge clk);
    check("R9 pulse one clock after underflow", 32'(irq[0]), 1);
    @(negedge clk);
    check("R9 pulse ends", 32'(irq[0]), 0);
    bus_rd(12'h018, d); check("R11 enable cleared, pending set", d, 32'h18);
    bus_rd(12'h010, d); check("R11 counter stays 0", d, 0);
    check("R12 ch1 line quiet", 32'(irq_pulses[1] - p1), 0);
    bus_wr(12'h018, 32'h08);
    bus_rd(12'h018, d); check("R10 pending kept on bit4=0", d, 32'h18);
    bus_wr(12'h018, 32'h10);
    bus_rd(12'h018, d); check("R10 pending cleared on bit4=1", d, 0);
  endtask

  task automatic t_no_ie;
    logic [31:0] d;
    int p0, p1, c;
    p1 = irq_pulses[1];
    bus_wr(12'h024, 32'h2);
    bus_wr(12'h028, 32'h0000_0007);
    repeat (30) @(negedge clk);
    check("R9 no pulse without interrupt enable", 32'(irq_pulses[1] - p1), 0);
    bus_rd(12'h028, d); check("R9 pending stays 0", d, 32'h3);
    p0 = irq_pulses[0];
    bus_wr(12'h028, 32'h0000_000B);
    wait_irq(1, c);
    wait_irq(1, c);
    check("R8 ch1 period (2+1)*(0+1)", 32'(c), 3);
    check("R12 ch0 line quiet while ch1 fires", 32'(irq_pulses[0] - p0), 0);
    bus_wr(12'h028, 32'h10);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    bus_rd(12'h00C, d); check("R6 unit +0xC reads 0", d, 0);
    bus_rd(12'h01C, d); check("R6 channel +0xC reads 0", d, 0);
    bus_wr(12'h034, 32'hDEAD_BEEF);
    bus_rd(12'h034, d); check("R6 absent channel reads 0", d, 0);
    bus_rd(12'h014, d); check("R6 ch0 reload untouched", d, 32'h5);
    bus_rd(12'h024, d); check("R6 ch1 reload untouched", d, 32'h2);
    bus_wr(12'h324, 32'h7);
    bus_rd(12'h024, d); check("R5 aliased write reaches ch1 reload", d, 32'h7);
    bus_wr(12'h010, 32'd100);
    bus_rd(12'h010, d); check("R5 counter write", d, 32'd100);
    repeat (5) @(negedge clk);
    bus_rd(12'h010, d); check("R8 disabled counter holds", d, 32'd100);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1'b1;
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_caps();
    t_prescaler();
    t_periodic();
    t_oneshot();
    t_no_ie();
    t_decode();
    if (!done) begin
      done = 1'b1;
      report();
    end
  end

endmodule